// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block sits behind a receive MAC and decides whether an incoming frame is wanted, looking only at its six-byte destination address. The address bytes arrive one per cycle in wire order, the first byte marked by a start strobe. While they stream in, the block runs a reflected CRC-32 over them and tracks two things: whether the address equals the station's own address, and whether it is the all-ones broadcast address.

When the sixth byte arrives, the block forms a decision:

- A group address (bit 0 of the first byte set) is looked up in a 64-bit hash table, using the low six bits of the CRC.
- An individual address must match the station address exactly.
- The broadcast address is governed by one reserved table bit.
- Two mode inputs bypass the lookup. One accepts every group address. The other accepts every frame.

The hash table is loaded through a simple byte-wide write port. A typical use is subscribing to IPv4 group addresses. Such a group maps to the MAC address 01:00:5E followed by the low 23 bits of the IP group address. Software computes the CRC index of that MAC address and sets the matching table bit.

Top module: `mcast_hash_filter`

## Requirements
- R1: The hash index is bits [5:0] of a CRC-32 with these properties: seeded with 0xFFFFFFFF, reflected polynomial 0xEDB88320, each byte taken LSB first, bytes in arrival order, and no final inversion.
- R2: Table byte k is written with tbl_wdata when tbl_we is high and tbl_sel equals k. Table bit i lives in byte i/8 at bit position i%8. A non-broadcast group address is accepted when its indexed bit is set, and rejected otherwise unless a bypass applies.
- R3: The broadcast address FF:FF:FF:FF:FF:FF is accepted exactly when bit 7 of table byte 7 (table bit 63) is set, unless promiscuous mode applies. The all-multicast mode has no effect on it.
- R4: With pass_all_mc high, every non-broadcast address whose first byte has bit 0 set is accepted.
- R5: With promisc high, every address is accepted.
- R6: An address whose first byte has bit 0 clear is accepted only when all six bytes equal station_addr. Byte k of the address is compared with station_addr[8k+7:8k], and byte 0 is the first byte on the wire.
- R7: decision_valid is a one-cycle pulse in the cycle after the sixth address byte is taken. accept carries the decision in that cycle and is 0 in every other cycle. The mode inputs are sampled in the sixth-byte cycle.
- R8: A byte with addr_first high always restarts the address. Valid bytes after the sixth, or before any start byte, are ignored and produce no decision.
- R9: After reset the table is all zero, and decision_valid and accept are 0.
- R10: A table write in the same cycle as the sixth address byte does not affect that address's decision. It takes effect from the next address on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Hash table byte write enable |
| tbl_sel | input | 3 | Hash table byte select |
| tbl_wdata | input | 8 | Hash table byte value |
| station_addr | input | 48 | Own address, first wire byte in bits [7:0] |
| pass_all_mc | input | 1 | Accept all group addresses |
| promisc | input | 1 | Accept all addresses |
| addr_valid | input | 1 | addr_byte carries an address byte |
| addr_first | input | 1 | This byte is the first of an address |
| addr_byte | input | 8 | Destination address byte |
| decision_valid | output | 1 | Decision pulse |
| accept | output | 1 | Frame accepted (valid with decision_valid) |

## Verification
The table write port and the lookup of a finished address can land on the same clock edge. The bench provokes this by writing the very table byte that holds the address's hash bit while driving the sixth address byte. It expects a rejection for that address. It then expects acceptance when the same address is sent again. A second overlap is a restart: a new start byte arrives in the middle of an address. The bench judges it by checking that the decision reflects only the restarted address.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;
endpackage

// File: rtl/mhf_crc_step.sv
// One byte of reflected CRC-32, all eight shift stages unrolled.
module mhf_crc_step #(
    parameter int DW = 8
) (
    input  logic [mhf_pkg::CRC_W-1:0] crc_in,
    input  logic [DW-1:0]             din,
    output logic [mhf_pkg::CRC_W-1:0] crc_out
);
    import mhf_pkg::*;

    logic [CRC_W-1:0] work;

    always_comb begin
        work = crc_in ^ {{(CRC_W-DW){1'b0}}, din};
        for (int i = 0; i < DW; i++) begin
            work = work[0] ? ((work >> 1) ^ CRC_POLY) : (work >> 1);
        end
        crc_out = work;
    end
endmodule

// File: rtl/mhf_hash_table.sv
// Byte-written hash table with a single-bit lookup port.
module mhf_hash_table #(
    parameter int NBYTES = 8,
    localparam int NBITS = NBYTES * 8,
    localparam int SEL_W = $clog2(NBYTES),
    localparam int IDX_W = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] idx,
    output logic             hit,
    output logic             top_bit
);
    logic [7:0]       tbl_q [NBYTES];
    logic [7:0]       tbl_d [NBYTES];
    logic [NBITS-1:0] flat;

    always_comb begin
        for (int b = 0; b < NBYTES; b++) begin
            tbl_d[b] = (we && (sel == SEL_W'(b))) ? wdata : tbl_q[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NBYTES; b++) tbl_q[b] <= '0;
        end else begin
            for (int b = 0; b < NBYTES; b++) tbl_q[b] <= tbl_d[b];
        end
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_flat
        assign flat[b*8 +: 8] = tbl_q[b];
    end

    assign hit     = flat[idx];
    assign top_bit = flat[NBITS-1];

    // R2: a written byte holds the written value on the next cycle
    p_table_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> tbl_q[$past(sel)] == $past(wdata));
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
    parameter int ADDR_BYTES = 6,
    parameter int TBL_BYTES  = 8,
    localparam int TBL_BITS = TBL_BYTES * 8,
    localparam int IDX_W    = $clog2(TBL_BITS),
    localparam int SEL_W    = $clog2(TBL_BYTES),
    localparam int CNT_W    = $clog2(ADDR_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tbl_we,
    input  logic [SEL_W-1:0]        tbl_sel,
    input  logic [7:0]              tbl_wdata,
    input  logic [ADDR_BYTES*8-1:0] station_addr,
    input  logic                    pass_all_mc,
    input  logic                    promisc,
    input  logic                    addr_valid,
    input  logic                    addr_first,
    input  logic [7:0]              addr_byte,
    output logic                    decision_valid,
    output logic                    accept
);
    import mhf_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;     // bytes taken; ADDR_BYTES means idle
        logic [CRC_W-1:0] crc;
        logic             match;   // equal to station so far
        logic             group;   // group bit of first byte
        logic             bcast;   // all ones so far
        logic             dvalid;
        logic             acc;
    } state_t;

    state_t s_q, s_d;

    logic [CRC_W-1:0] crc_base, crc_nx;
    logic             tbl_hit, tbl_bcast;
    logic [CNT_W-1:0] pos;
    logic             take;
    logic [7:0]       sta_byte;

    assign crc_base = addr_first ? CRC_SEED : s_q.crc;

    mhf_crc_step #(.DW(8)) u_crc (
        .crc_in (crc_base),
        .din    (addr_byte),
        .crc_out(crc_nx)
    );

    mhf_hash_table #(.NBYTES(TBL_BYTES)) u_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (tbl_we),
        .sel    (tbl_sel),
        .wdata  (tbl_wdata),
        .idx    (crc_nx[IDX_W-1:0]),
        .hit    (tbl_hit),
        .top_bit(tbl_bcast)
    );

    always_comb begin
        s_d        = s_q;
        s_d.dvalid = 1'b0;
        s_d.acc    = 1'b0;
        pos        = addr_first ? '0 : s_q.cnt;
        take       = addr_valid && (addr_first || (s_q.cnt != CNT_W'(ADDR_BYTES)));
        sta_byte   = station_addr[int'(pos)*8 +: 8];
        if (take) begin
            s_d.cnt   = pos + CNT_W'(1);
            s_d.crc   = crc_nx;
            s_d.match = (addr_first | s_q.match) & (addr_byte == sta_byte);
            s_d.bcast = (addr_first | s_q.bcast) & (addr_byte == 8'hFF);
            s_d.group = addr_first ? addr_byte[0] : s_q.group;
            if (pos == CNT_W'(ADDR_BYTES - 1)) begin
                s_d.dvalid = 1'b1;
                if (promisc)        s_d.acc = 1'b1;
                else if (!s_d.group) s_d.acc = s_d.match;
                else if (s_d.bcast) s_d.acc = tbl_bcast;
                else                s_d.acc = pass_all_mc | tbl_hit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.cnt <= CNT_W'(ADDR_BYTES);
        end else begin
            s_q <= s_d;
        end
    end

    assign decision_valid = s_q.dvalid;
    assign accept         = s_q.acc;

    // R7: the decision is a single-cycle pulse
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        decision_valid |=> !decision_valid);
    // R7: a decision always follows a taken byte
    p_after_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        decision_valid |-> $past(addr_valid));
    // R7: accept is quiet outside the pulse
    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !decision_valid |-> !accept);
    // R5: promiscuous mode accepts everything
    p_promisc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (decision_valid && $past(promisc)) |-> accept);
    // R4: all-multicast accepts any non-broadcast group address
    p_pass_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (decision_valid && $past(pass_all_mc) && s_q.group && !s_q.bcast) |-> accept);
    // R8: a start byte restarts the count
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && addr_first) |=> (s_q.cnt == CNT_W'(1)));
endmodule

// File: tb/mcast_hash_filter_tb.sv
`timescale 1ns/1ps
module mcast_hash_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [2:0]  tbl_sel = '0;
    logic [7:0]  tbl_wdata = '0;
    logic [47:0] station_addr;
    logic        pass_all_mc = 1'b0;
    logic        promisc = 1'b0;
    logic        addr_valid = 1'b0;
    logic        addr_first = 1'b0;
    logic [7:0]  addr_byte = '0;
    logic        decision_valid, accept;

    int errors = 0;
    int checks = 0;
    logic [63:0] mdl_tbl = '0;

    // station 02:12:34:56:78:9A, first wire byte in [7:0]
    localparam logic [47:0] STA = 48'h9A78_5634_1202;
    localparam logic [47:0] IPV4_GRP = 48'h0302_015E_0001; // 01:00:5E:01:02:03 from 239.1.2.3
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

    // {promisc, pass_all, address}
    localparam logic [49:0] VEC [9] = '{
        {2'b00, IPV4_GRP},
        {2'b00, 48'h0100_0000_3333},
        {2'b00, STA},
        {2'b00, 48'h9B78_5634_1202},
        {2'b01, 48'h010E_0D0C_0B0A ^ 48'h0000_0000_0001 | 48'h0000_0000_0001},
        {2'b00, 48'h0A0B_0C0D_0E01},
        {2'b10, 48'h6655_4433_2211 & 48'hFFFF_FFFF_FFFE},
        {2'b00, BCAST},
        {2'b01, BCAST}
    };

    mcast_hash_filter u_dut (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_sel(tbl_sel),
        .tbl_wdata(tbl_wdata), .station_addr(station_addr),
        .pass_all_mc(pass_all_mc), .promisc(promisc), .addr_valid(addr_valid),
        .addr_first(addr_first), .addr_byte(addr_byte),
        .decision_valid(decision_valid), .accept(accept)
    );

    always #4 clk = ~clk;

    function automatic logic [5:0] hash_idx(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            c ^= {24'h0, a[8*k +: 8]};
            for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return c[5:0];
    endfunction

    function automatic logic expect_acc(input logic [47:0] a, input logic pr, input logic pa);
        if (pr) return 1'b1;
        if (!a[0]) return a == STA;
        if (a == BCAST) return mdl_tbl[63];
        return pa | mdl_tbl[hash_idx(a)];
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_sel = s; tbl_wdata = d;
        @(negedge clk);
        tbl_we = 1'b0;
        mdl_tbl[8*s +: 8] = d;
    endtask

    task automatic send(input logic [47:0] a, input logic pr, input logic pa,
                        input logic sw, input logic [2:0] ws, input logic [7:0] wd,
                        output logic dv, output logic ac);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            addr_valid = 1'b1; addr_first = (k == 0); addr_byte = a[8*k +: 8];
            promisc = pr; pass_all_mc = pa;
            if (k == 5 && sw) begin tbl_we = 1'b1; tbl_sel = ws; tbl_wdata = wd; end
        end
        @(posedge clk); #1;
        dv = decision_valid; ac = accept;
        @(negedge clk);
        addr_valid = 1'b0; addr_first = 1'b0; tbl_we = 1'b0;
        promisc = 1'b0; pass_all_mc = 1'b0;
        if (sw) mdl_tbl[8*ws +: 8] = wd;
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic dv, ac, seen;
        logic [5:0] gi;
        station_addr = STA;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 decision_valid at reset", decision_valid, 1'b0);
        check("R9 accept at reset", accept, 1'b0);
        rst_n = 1'b1;
        // R8 bytes before any start byte are ignored
        seen = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); addr_valid = 1'b1; addr_byte = STA[8*(k%6) +: 8];
            @(posedge clk); #1; seen |= decision_valid;
        end
        @(negedge clk); addr_valid = 1'b0;
        check("R8 no decision without start byte", seen, 1'b0);
        // R9 empty table rejects the group address
        send(IPV4_GRP, 0, 0, 0, 0, 0, dv, ac);
        check("R9 empty table rejects group", ac, 1'b0);
        check("R7 decision pulse", dv, 1'b1);
        // program: broadcast bit plus the hash bit of the IPv4 group
        gi = hash_idx(IPV4_GRP);
        wr(3'd7, 8'h80);
        wr(gi[5:3], mdl_tbl[8*gi[5:3] +: 8] | (8'h1 << gi[2:0]));
        // R1 R2 R3 R4 R5 R6 vector walk
        for (int v = 0; v < 9; v++) begin
            send(VEC[v][47:0], VEC[v][49], VEC[v][48], 0, 0, 0, dv, ac);
            check($sformatf("R7 vector %0d valid", v), dv, 1'b1);
            check($sformatf("R1 R2 R3 R4 R5 R6 vector %0d accept", v), ac,
                  expect_acc(VEC[v][47:0], VEC[v][49], VEC[v][48]));
        end
        // R2 bit mapping: group accepted only when its own bit set
        check("R2 group hit accepted", expect_acc(IPV4_GRP, 0, 0), 1'b1);
        wr(gi[5:3], mdl_tbl[8*gi[5:3] +: 8] & ~(8'h1 << gi[2:0]));
        send(IPV4_GRP, 0, 0, 0, 0, 0, dv, ac);
        check("R2 cleared bit rejects", ac, 1'b0);
        // R3 broadcast off, all-multicast has no effect
        wr(3'd7, mdl_tbl[63:56] & 8'h7F);
        send(BCAST, 0, 1, 0, 0, 0, dv, ac);
        check("R3 broadcast rejected with bit 63 clear", ac, 1'b0);
        send(BCAST, 1, 0, 0, 0, 0, dv, ac);
        check("R5 promisc accepts broadcast", ac, 1'b1);
        // R10 same-cycle write does not affect current decision
        send(IPV4_GRP, 0, 0, 1, gi[5:3], mdl_tbl[8*gi[5:3] +: 8] | (8'h1 << gi[2:0]), dv, ac);
        check("R10 same-cycle write uses old table", ac, 1'b0);
        send(IPV4_GRP, 0, 0, 0, 0, 0, dv, ac);
        check("R10 write effective next address", ac, 1'b1);
        // R8 extra bytes after the sixth are ignored
        seen = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); addr_valid = 1'b1; addr_byte = 8'h01;
            @(posedge clk); #1; seen |= decision_valid;
        end
        @(negedge clk); addr_valid = 1'b0;
        check("R8 trailing bytes ignored", seen, 1'b0);
        // R8 restart mid-address: only the restarted address counts
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); addr_valid = 1'b1; addr_first = (k == 0); addr_byte = 8'hFF;
        end
        send(STA, 0, 0, 0, 0, 0, dv, ac);
        check("R8 restart decision valid", dv, 1'b1);
        check("R6 R8 restarted station address accepted", ac, 1'b1);
        // R7 accept low after the pulse
        @(posedge clk); #1;
        check("R7 accept idle", accept, 1'b0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule